// File: doc/BRIEF.md
# Synchronous Serial Port Master with FIFO Status

This block is a serial port master that moves 8-bit frames over a four-wire SPI link in mode 0. Clock idles low, data is sampled on the rising edge and changed on the falling edge, and the most significant bit goes first. Software loads transmit words through a small register port. Each word waits in an 8-entry transmit queue until the frame engine takes it. The word shifted in during the same frame lands in an 8-entry receive queue, and software reads it from the data register.

The bit clock comes from the peripheral clock through two stages in series. The first is a prescaler that only takes even divisors. The second is a rate divider of SCR+1. The bit period is therefore PRESCALE × (SCR+1) peripheral clock cycles. A status word reports queue levels and whether the engine still has work. No frame starts while the prescaler holds zero, so software must set the divisor before data will move.

Register map, selected by `reg_addr`:
- 0: control. SCR sits in bits 15:8.
- 1: prescale. Bits 7:0 hold the divisor.
- 2: data. A write queues a word. A read pops a received word.
- 3: status.

Top module: `serial_port_master`

## Requirements
- R1: After reset, the status register (address 3) reads 0x03. That is TX-empty (bit 0)=1, TX-not-full (bit 1)=1, RX-not-empty (bit 2)=0, RX-full (bit 3)=0 and busy (bit 4)=0. The prescale register reads 0, SSEL is high and SCK is low.
- R2: The prescale register keeps only bits 7:0 of a write, and bit 0 always reads 0. Writing 0x07 reads back 0x06, and writing 0x1FF reads back 0xFE.
- R3: While the prescale register holds 0, no frame starts. SSEL stays high, and queued words stay in the transmit queue.
- R4: Within a frame, successive rising SCK edges are PRESCALE × (SCR+1) peripheral clock cycles apart. SCR is control bits 15:8 and reads back there.
- R5: Each frame carries 8 bits, MSB first, in mode 0. MOSI never changes at a rising SCK edge. The word received is made of MISO as sampled on the 8 rising edges, MSB first.
- R6: SSEL goes low for each frame, with exactly 8 rising SCK edges inside it. SSEL returns high for at least one cycle between frames.
- R7: The transmit queue holds 8 words. With 8 waiting, TX-not-full reads 0. A data write to the full queue is dropped and never transmitted.
- R8: The receive queue holds 8 words. RX-not-empty is 1 when the queue holds at least one word, and RX-full is 1 when it holds 8. A frame that completes while the queue is full loses its word. A data read from the empty queue returns 0.
- R9: Busy is 1 while a frame is in progress or the transmit queue is not empty, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read pops the receive queue) |
| reg_addr | input | 2 | Register select: 0 control, 1 prescale, 2 data, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register, combinational |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ssel_n | output | 1 | Active-low slave select |

## Verification
Register writes take effect at the next clock edge, and a read reports current state in the same cycle. The bench therefore drives on the falling edge and samples read data 1 ns later. Serial results arrive over a whole frame, so the bench does not predict frame latency. It polls busy until it falls and then compares queue contents and status. The pin monitor samples SCK, MOSI and SSEL at every rising clock edge. It measures the gap between rising SCK edges in cycles against PRESCALE × (SCR+1), and it checks each frame's MOSI bits against the words queued at the time of the write.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_PRESCL = 2'd1,
        ADDR_DATA   = 2'd2,
        ADDR_STATUS = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_XFER = 1'b1
    } eng_state_e;

    localparam int STAT_TX_EMPTY = 0;
    localparam int STAT_TX_NFULL = 1;
    localparam int STAT_RX_NEMPT = 2;
    localparam int STAT_RX_FULL  = 3;
    localparam int STAT_BUSY     = 4;

    localparam int RATE_LSB = 8;

endpackage

// File: rtl/spm_fifo.sv
module spm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wptr;
        logic [AW-1:0]           rptr;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t s_d, s_q;
    logic  push_ok, pop_ok;

    assign empty   = (s_q.cnt == '0);
    assign full    = (s_q.cnt == DEPTH_C);
    assign rdata   = s_q.mem[s_q.rptr];
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push_ok) begin
            s_d.mem[s_q.wptr] = wdata;
            s_d.wptr          = ptr_inc(s_q.wptr);
        end
        if (pop_ok) begin
            s_d.rptr = ptr_inc(s_q.rptr);
        end
        case ({push_ok, pop_ok})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= DEPTH_C);

    assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/spm_clkgen.sv
module spm_clkgen #(
    parameter int PW = 8,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] cpsdvsr,
    input  logic [RW-1:0] scr,
    output logic          edge_o
);
    typedef struct packed {
        logic [PW-2:0] pre;
        logic [RW-1:0] rate;
    } div_t;

    div_t          c_d, c_q;
    logic [PW-2:0] half_m1;
    logic          pre_wrap;
    logic          rate_wrap;

    assign half_m1   = cpsdvsr[PW-1:1] - {{(PW-2){1'b0}}, 1'b1};
    assign pre_wrap  = (c_q.pre == half_m1);
    assign rate_wrap = (c_q.rate == scr);
    assign edge_o    = run && pre_wrap && rate_wrap;

    always_comb begin
        c_d = c_q;
        if (!run) begin
            c_d = '0;
        end else if (pre_wrap) begin
            c_d.pre  = '0;
            c_d.rate = rate_wrap ? '0 : c_q.rate + 1'b1;
        end else begin
            c_d.pre = c_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assert_run_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cpsdvsr != '0 && !cpsdvsr[0]));

endmodule

// File: rtl/spm_shifter.sv
module spm_shifter
    import spm_pkg::*;
#(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_ok,
    input  logic [FW-1:0] tx_data,
    output logic          tx_pop,
    input  logic          edge_i,
    output logic          run_o,
    input  logic          miso,
    output logic          sck,
    output logic          mosi,
    output logic          ssel_n,
    output logic          rx_push,
    output logic [FW-1:0] rx_data
);
    localparam int BW = (FW > 1) ? $clog2(FW) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(FW - 1);

    typedef struct packed {
        eng_state_e    st;
        logic [FW-1:0] sh;
        logic [FW-1:0] rx;
        logic [BW-1:0] bitn;
        logic          sck;
        logic          mosi;
        logic          ssel_n;
    } eng_t;

    eng_t e_d, e_q;
    logic last_fall;

    assign last_fall = (e_q.st == ENG_XFER) && edge_i && e_q.sck && (e_q.bitn == LAST_BIT);
    assign tx_pop    = (e_q.st == ENG_IDLE) && start_ok;
    assign run_o     = (e_q.st == ENG_XFER);
    assign rx_push   = last_fall;
    assign rx_data   = e_q.rx;
    assign sck       = e_q.sck;
    assign mosi      = e_q.mosi;
    assign ssel_n    = e_q.ssel_n;

    always_comb begin
        e_d = e_q;
        case (e_q.st)
            ENG_IDLE: begin
                if (start_ok) begin
                    e_d.st     = ENG_XFER;
                    e_d.sh     = tx_data;
                    e_d.mosi   = tx_data[FW-1];
                    e_d.ssel_n = 1'b0;
                    e_d.sck    = 1'b0;
                    e_d.bitn   = '0;
                    e_d.rx     = '0;
                end
            end
            ENG_XFER: begin
                if (edge_i) begin
                    if (!e_q.sck) begin
                        e_d.sck = 1'b1;
                        e_d.rx  = {e_q.rx[FW-2:0], miso};
                    end else begin
                        e_d.sck = 1'b0;
                        if (e_q.bitn == LAST_BIT) begin
                            e_d.st     = ENG_IDLE;
                            e_d.ssel_n = 1'b1;
                        end else begin
                            e_d.bitn = e_q.bitn + 1'b1;
                            e_d.sh   = {e_q.sh[FW-2:0], 1'b0};
                            e_d.mosi = e_q.sh[FW-2];
                        end
                    end
                end
            end
            default: e_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q        <= '0;
            e_q.st     <= ENG_IDLE;
            e_q.ssel_n <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assert_mosi_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_q.sck) |-> $stable(e_q.mosi));

    assert_frame_end_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_q.ssel_n) |-> !e_q.sck);

endmodule

// File: rtl/serial_port_master.sv
module serial_port_master
    import spm_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FRAME_W    = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int PRE_W      = 8,
    parameter int RATE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_ssel_n
);
    typedef struct packed {
        logic [RATE_W-1:0] scr;
        logic [PRE_W-1:0]  cpsdvsr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic               tx_push, tx_pop, tx_empty, tx_full;
    logic [FRAME_W-1:0] tx_head;
    logic               rx_push, rx_pop, rx_empty, rx_full;
    logic [FRAME_W-1:0] rx_head, rx_word;
    logic               start_ok, eng_run, div_edge;
    logic               busy;
    reg_addr_e          addr;

    assign addr     = reg_addr_e'(reg_addr);
    assign tx_push  = reg_wr && (addr == ADDR_DATA);
    assign rx_pop   = reg_rd && (addr == ADDR_DATA) && !rx_empty;
    assign start_ok = !tx_empty && (cfg_q.cpsdvsr != '0);
    assign busy     = eng_run || !tx_empty;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            case (addr)
                ADDR_CTRL:   cfg_d.scr     = reg_wdata[RATE_LSB +: RATE_W];
                ADDR_PRESCL: cfg_d.cpsdvsr = {reg_wdata[PRE_W-1:1], 1'b0};
                default:     cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (addr)
            ADDR_CTRL:   reg_rdata[RATE_LSB +: RATE_W] = cfg_q.scr;
            ADDR_PRESCL: reg_rdata[PRE_W-1:0]          = cfg_q.cpsdvsr;
            ADDR_DATA:   reg_rdata[FRAME_W-1:0]        = rx_empty ? '0 : rx_head;
            ADDR_STATUS: begin
                reg_rdata[STAT_TX_EMPTY] = tx_empty;
                reg_rdata[STAT_TX_NFULL] = !tx_full;
                reg_rdata[STAT_RX_NEMPT] = !rx_empty;
                reg_rdata[STAT_RX_FULL]  = rx_full;
                reg_rdata[STAT_BUSY]     = busy;
            end
            default: reg_rdata = '0;
        endcase
    end

    spm_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .wdata(reg_wdata[FRAME_W-1:0]),
        .pop(tx_pop), .rdata(tx_head),
        .empty(tx_empty), .full(tx_full)
    );

    spm_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head),
        .empty(rx_empty), .full(rx_full)
    );

    spm_clkgen #(.PW(PRE_W), .RW(RATE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(eng_run),
        .cpsdvsr(cfg_q.cpsdvsr), .scr(cfg_q.scr), .edge_o(div_edge)
    );

    spm_shifter #(.FW(FRAME_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start_ok(start_ok), .tx_data(tx_head), .tx_pop(tx_pop),
        .edge_i(div_edge), .run_o(eng_run),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .ssel_n(spi_ssel_n),
        .rx_push(rx_push), .rx_data(rx_word)
    );

    assert_prescale_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.cpsdvsr[0]);

    assert_no_start_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.cpsdvsr == '0 && spi_ssel_n) |=> spi_ssel_n);

    assert_busy_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_ssel_n |-> busy);

endmodule

// File: tb/serial_port_master_bench.sv
module serial_port_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_mosi, spi_miso, spi_ssel_n;

    int checks = 0, errors = 0;
    int exp_per = 0;
    int frames = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #4 clk = ~clk;

    // loopback slave: returns the inverse of what it hears
    assign spi_miso = ~spi_mosi;

    serial_port_master u_serial_port_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_ssel_n(spi_ssel_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // driver: queue a word and record what the pins and rx queue should show
    task automatic send(input logic [7:0] b, input bit tx_taken, input bit rx_kept);
        wr(2'd2, {24'h0, b});
        if (tx_taken) txq.push_back(b);
        if (rx_kept) rxq.push_back(~b);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd3, s);
            if (!s[4]) return;
        end
        check(1'b0, "R9 idle timeout", s, 32'h0);
    endtask

    // scoreboard consumer for the receive path
    task automatic drain(input int n);
        logic [31:0] d;
        for (int i = 0; i < n; i++) begin
            rd(2'd2, d);
            if (rxq.size() == 0) check(1'b0, "R8 unexpected rx word", d, 32'h0);
            else begin
                logic [7:0] e;
                e = rxq.pop_front();
                check(d == {24'h0, e}, "R5 rx word", d, {24'h0, e});
            end
        end
    endtask

    // pin monitor: bit period, bits per frame, MOSI order
    int   cyc = 0, last_rise = 0, rises = 0;
    logic sck_prev = 1'b0, ssel_prev = 1'b1;
    logic [7:0] mosi_word = '0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        sck_prev  <= spi_sck;
        ssel_prev <= spi_ssel_n;
        if (rst_n) begin
            if (!spi_ssel_n && spi_sck && !sck_prev) begin
                if (rises > 0)
                    check(cyc - last_rise == exp_per, "R4 sck period", cyc - last_rise, exp_per);
                last_rise <= cyc;
                rises     <= rises + 1;
                mosi_word <= {mosi_word[6:0], spi_mosi};
            end
            if (spi_ssel_n && !ssel_prev) begin
                frames <= frames + 1;
                check(rises == 8, "R6 rising edges per frame", rises, 8);
                if (txq.size() == 0) check(1'b0, "R7 frame without queued word", mosi_word, 0);
                else begin
                    logic [7:0] e;
                    e = txq.pop_front();
                    check(mosi_word == e, "R5 mosi word msb first", mosi_word, e);
                end
                rises <= 0;
            end
        end
    end

    bit done = 1'b0;
    initial begin
        #(8 * 150000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd3, d); check(d == 32'h03, "R1 status after reset", d, 32'h03);
        rd(2'd1, d); check(d == 32'h00, "R1 prescale after reset", d, 32'h00);
        check(spi_ssel_n && !spi_sck, "R1 pins idle", {spi_ssel_n, spi_sck}, 2'b10);

        wr(2'd1, 32'h07);  rd(2'd1, d); check(d == 32'h06, "R2 odd masked", d, 32'h06);
        wr(2'd1, 32'h1FF); rd(2'd1, d); check(d == 32'hFE, "R2 upper bits dropped", d, 32'hFE);
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h0300); rd(2'd0, d); check(d == 32'h0300, "R4 rate field readback", d, 32'h0300);

        send(8'hA5, 1, 1);
        repeat (40) @(negedge clk);
        check(spi_ssel_n == 1'b1, "R3 no frame with zero divisor", spi_ssel_n, 1);
        rd(2'd3, d); check(d == 32'h12, "R3 R9 word held, busy", d, 32'h12);

        exp_per = 16; wr(2'd1, 32'h04);
        wait_idle();
        rd(2'd3, d); check(d == 32'h07, "R8 R9 one word received, idle", d, 32'h07);
        drain(1);

        wr(2'd1, 32'h0); wr(2'd0, 32'h0); exp_per = 2;
        send(8'h3C, 1, 1); send(8'h81, 1, 1);
        wr(2'd1, 32'h02);
        wait_idle(); drain(2);

        wr(2'd1, 32'h0); wr(2'd0, 32'h0200); exp_per = 18;
        send(8'hF0, 1, 1);
        wr(2'd1, 32'h06);
        wait_idle(); drain(1);

        wr(2'd1, 32'h0); wr(2'd0, 32'h0); exp_per = 2;
        for (int i = 0; i < 8; i++) send(8'h10 + 8'(i), 1, 1);
        rd(2'd3, d); check(d == 32'h10, "R7 tx full, not-full flag clear", d, 32'h10);
        send(8'hEE, 0, 0);
        wr(2'd1, 32'h02);
        wait_idle();
        rd(2'd3, d); check(d == 32'h0F, "R8 rx full", d, 32'h0F);
        send(8'h5A, 1, 0);
        wait_idle();
        rd(2'd3, d); check(d == 32'h0F, "R8 overflow frame dropped", d, 32'h0F);
        drain(8);
        rd(2'd3, d); check(d == 32'h03, "R8 R9 all drained", d, 32'h03);
        rd(2'd2, d); check(d == 32'h0, "R8 empty read is zero", d, 32'h0);
        repeat (4) @(negedge clk);
        check(frames == 13, "R6 R7 frame count", frames, 13);
        check(txq.size() == 0, "R7 every queued word sent", txq.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule